// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration front end of a legacy-style I/O chip. A host reaches it through two byte-wide addresses on a simple strobed bus. The lower address holds a register index and the next address up carries the data for that index. The whole space stays closed until the host writes an opening key byte to the index address. A closing key byte written to the same address shuts it again.

Once open, the port gives access to a fixed chip identification byte and to a logical-device selector. It also gives access to three registers that belong to the selected logical device: an activation flag and a 16-bit base address split over two indices. Only the embedded-controller logical device has storage behind those registers. For every other selector value they read as zero and ignore writes. Reads come back one clock after the strobe, together with a valid pulse.

Top module: `cfg_port_top`

## Requirements
- R1: After reset the port is closed: reads of the data address and of the index address both return 0xFF. The selector resets to 0x00, the activation flag to 1 and the base address to the BASE_RST parameter.
- R2: Writing 0x55 to the index address while closed opens the port. Writing 0xAA to the index address while open closes it. Any other index write while open stores the byte as the current index. Index writes while closed have no other effect.
- R3: While closed, writes to the data address change no register, and the stored index is kept.
- R4: Index 0x20 reads the chip ID: 0xC6 when ALT_ID is 0, 0xC7 when ALT_ID is 1. Writes to it are ignored.
- R5: Index 0x07 is the logical-device selector, an 8-bit read/write register. While open, reading the index address returns the stored index.
- R6: For the embedded-controller device (selector 0x0C), index 0x30 holds the activation flag in bit 0. Bits 7..1 read as 0, and a write sets the flag from data bit 0.
- R7: For the embedded-controller device, index 0x66 holds the base-address low byte and index 0x67 holds the high byte. Both are read/write.
- R8: When the selector is not 0x0C, indices 0x30, 0x66 and 0x67 read 0x00 and writes to them are ignored. The stored values reappear when 0x0C is selected again.
- R9: Any index other than 0x07, 0x20, 0x30, 0x66 and 0x67 reads 0x00 while the port is open.
- R10: Bus accesses to addresses other than PORT_BASE and PORT_BASE+1 change no state and produce no read-valid pulse.
- R11: A read strobe to either port address sets rd_valid high, with rdata, in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response pulse |

## Verification
The hardest state to reach is an index that was stored before the port was closed and then has to survive closed-state writes to both addresses. The stimulus stores index 0x66 and gives the base low byte a known value. It then closes the port, writes to the data address and a non-key byte to the index address, and reopens. Reading back the index address and the data address shows that neither was disturbed. The banked registers are checked the same way: the selector moves away from 0x0C, a write is attempted, and the selector moves back so the old contents can be read.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam logic [7:0] KEY_OPEN    = 8'h55;
    localparam logic [7:0] KEY_CLOSE   = 8'hAA;

    localparam logic [7:0] IDX_LDSEL   = 8'h07;
    localparam logic [7:0] IDX_CHIPID  = 8'h20;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_LO = 8'h66;
    localparam logic [7:0] IDX_BASE_HI = 8'h67;

    localparam logic [7:0] CHIP_ID_A   = 8'hC6;
    localparam logic [7:0] CHIP_ID_B   = 8'hC7;

    localparam logic [7:0] CLOSED_READ = 8'hFF;

    typedef struct packed {
        logic idx_wr;
        logic dat_wr;
        logic idx_rd;
        logic dat_rd;
    } port_op_t;

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
    import cfg_port_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_BASE = 16'h004E
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output port_op_t          op
);

    localparam logic [ADDR_W-1:0] IDX_ADDR = PORT_BASE;
    localparam logic [ADDR_W-1:0] DAT_ADDR = PORT_BASE + 1'b1;

    logic hit_idx;
    logic hit_dat;

    always_comb begin
        hit_idx   = (addr == IDX_ADDR);
        hit_dat   = (addr == DAT_ADDR);
        op.idx_wr = wr & hit_idx;
        op.dat_wr = wr & hit_dat;
        op.idx_rd = rd & hit_idx;
        op.dat_rd = rd & hit_dat;
    end

endmodule

// File: rtl/cfg_port_lock.sv
module cfg_port_lock
    import cfg_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  port_op_t   op,
    input  logic [7:0] wdata,
    output logic       locked,
    output logic [7:0] index
);

    typedef struct packed {
        logic       locked;
        logic [7:0] index;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op.idx_wr) begin
            if (st_q.locked) begin
                if (wdata == KEY_OPEN) st_d.locked = 1'b0;
            end else if (wdata == KEY_CLOSE) begin
                st_d.locked = 1'b1;
            end else begin
                st_d.index = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.locked <= 1'b1;
            st_q.index  <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;
    assign index  = st_q.index;

    a_r2_open_key: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && op.idx_wr && wdata == KEY_OPEN) |=> !locked);

    a_r2_close_key: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && op.idx_wr && wdata == KEY_CLOSE) |=> locked);

    a_r3_index_kept_closed: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(index));

endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
    import cfg_port_pkg::*;
#(
    parameter logic [7:0]  EC_LDN   = 8'h0C,
    parameter logic [15:0] BASE_RST = 16'h0A40,
    parameter bit          ALT_ID   = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       locked,
    input  logic [7:0] index,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic [7:0] rd_byte
);

    typedef struct packed {
        logic [7:0]  ldsel;
        logic        act;
        logic [15:0] base;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [7:0] chip_id;
    logic       ec_sel;
    logic       wr_ok;

    generate
        if (ALT_ID) begin : g_id_b
            assign chip_id = CHIP_ID_B;
        end else begin : g_id_a
            assign chip_id = CHIP_ID_A;
        end
    endgenerate

    always_comb begin
        ec_sel = (st_q.ldsel == EC_LDN);
        wr_ok  = dat_wr & ~locked;
        st_d   = st_q;
        if (wr_ok) begin
            unique case (index)
                IDX_LDSEL:   st_d.ldsel = wdata;
                IDX_ACT:     if (ec_sel) st_d.act = wdata[0];
                IDX_BASE_LO: if (ec_sel) st_d.base[7:0] = wdata;
                IDX_BASE_HI: if (ec_sel) st_d.base[15:8] = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (index)
            IDX_LDSEL:   rd_byte = st_q.ldsel;
            IDX_CHIPID:  rd_byte = chip_id;
            IDX_ACT:     rd_byte = ec_sel ? {7'b0, st_q.act} : 8'h00;
            IDX_BASE_LO: rd_byte = ec_sel ? st_q.base[7:0] : 8'h00;
            IDX_BASE_HI: rd_byte = ec_sel ? st_q.base[15:8] : 8'h00;
            default:     rd_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ldsel <= 8'h00;
            st_q.act   <= 1'b1;
            st_q.base  <= BASE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    a_r3_closed_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && dat_wr) |=> ($stable(st_q.ldsel) && $stable(st_q.act) && $stable(st_q.base)));

    a_r8_bank_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ldsel != EC_LDN) |=> ($stable(st_q.act) && $stable(st_q.base)));

    a_r6_act_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (index == IDX_ACT) |-> (rd_byte[7:1] == 7'b0));

endmodule

// File: rtl/cfg_port_top.sv
module cfg_port_top
    import cfg_port_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_BASE = 16'h004E,
    parameter logic [7:0]        EC_LDN    = 8'h0C,
    parameter logic [15:0]       BASE_RST  = 16'h0A40,
    parameter bit                ALT_ID    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rvalid
);

    port_op_t   op;
    logic       locked;
    logic [7:0] index;
    logic [7:0] reg_byte;

    typedef struct packed {
        logic [7:0] rdata;
        logic       rvalid;
    } rsp_st_t;

    rsp_st_t rsp_d, rsp_q;

    cfg_port_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_BASE (PORT_BASE)
    ) decode_i (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .op   (op)
    );

    cfg_port_lock lock_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .wdata  (bus_wdata),
        .locked (locked),
        .index  (index)
    );

    cfg_port_regs #(
        .EC_LDN   (EC_LDN),
        .BASE_RST (BASE_RST),
        .ALT_ID   (ALT_ID)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .locked  (locked),
        .index   (index),
        .dat_wr  (op.dat_wr),
        .wdata   (bus_wdata),
        .rd_byte (reg_byte)
    );

    always_comb begin
        rsp_d.rvalid = op.idx_rd | op.dat_rd;
        rsp_d.rdata  = rsp_q.rdata;
        if (op.idx_rd) begin
            rsp_d.rdata = locked ? CLOSED_READ : index;
        end else if (op.dat_rd) begin
            rsp_d.rdata = locked ? CLOSED_READ : reg_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q.rdata  <= 8'h00;
            rsp_q.rvalid <= 1'b0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign bus_rdata  = rsp_q.rdata;
    assign bus_rvalid = rsp_q.rvalid;

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == PORT_BASE || bus_addr == PORT_BASE + 1'b1)) |=> bus_rvalid);

    a_r10_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(op.idx_rd || op.dat_rd) |=> !bus_rvalid);

    a_r1_closed_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(locked)) |-> (bus_rdata == CLOSED_READ));

endmodule

// File: tb/cfg_port_top_tb_top.sv
module cfg_port_top_tb_top;

    localparam logic [15:0] IDX_A = 16'h004E;
    localparam logic [15:0] DAT_A = 16'h004F;

    localparam logic [1:0] OP_WI = 2'd0;
    localparam logic [1:0] OP_WD = 2'd1;
    localparam logic [1:0] OP_RI = 2'd2;
    localparam logic [1:0] OP_RD = 2'd3;

    localparam int NV = 48;
    // {op, value, expected, requirement number}
    localparam logic [21:0] VEC [NV] = '{
        {OP_RD, 8'h00, 8'hFF, 4'd1},   // R1 closed data read
        {OP_RI, 8'h00, 8'hFF, 4'd1},   // R1 closed index read
        {OP_WI, 8'h55, 8'h00, 4'd2},   // R2 open
        {OP_RI, 8'h00, 8'h00, 4'd5},   // R5 index read back
        {OP_RD, 8'h00, 8'h00, 4'd9},   // R9 index 0 unimplemented
        {OP_WI, 8'h20, 8'h00, 4'd4},
        {OP_RD, 8'h00, 8'hC6, 4'd4},   // R4 chip id
        {OP_WD, 8'h12, 8'h00, 4'd4},
        {OP_RD, 8'h00, 8'hC6, 4'd4},   // R4 id read-only
        {OP_WI, 8'h07, 8'h00, 4'd5},
        {OP_RD, 8'h00, 8'h00, 4'd1},   // R1 selector reset
        {OP_WI, 8'h30, 8'h00, 4'd8},
        {OP_RD, 8'h00, 8'h00, 4'd8},   // R8 hidden bank
        {OP_WD, 8'h00, 8'h00, 4'd8},
        {OP_WI, 8'h66, 8'h00, 4'd8},
        {OP_RD, 8'h00, 8'h00, 4'd8},   // R8 hidden bank
        {OP_WI, 8'h07, 8'h00, 4'd5},
        {OP_WD, 8'h0C, 8'h00, 4'd5},
        {OP_RD, 8'h00, 8'h0C, 4'd5},   // R5 selector write
        {OP_WI, 8'h30, 8'h00, 4'd6},
        {OP_RD, 8'h00, 8'h01, 4'd6},   // R6 flag reset 1 (R8 write was ignored)
        {OP_WD, 8'hFE, 8'h00, 4'd6},
        {OP_RD, 8'h00, 8'h00, 4'd6},   // R6 bit0 cleared
        {OP_WD, 8'h03, 8'h00, 4'd6},
        {OP_RD, 8'h00, 8'h01, 4'd6},   // R6 upper bits read 0
        {OP_WI, 8'h66, 8'h00, 4'd7},
        {OP_RD, 8'h00, 8'h40, 4'd7},   // R7 low byte reset
        {OP_WI, 8'h67, 8'h00, 4'd7},
        {OP_RD, 8'h00, 8'h0A, 4'd7},   // R7 high byte reset
        {OP_WD, 8'h5A, 8'h00, 4'd7},
        {OP_RD, 8'h00, 8'h5A, 4'd7},   // R7 high write
        {OP_WI, 8'h66, 8'h00, 4'd7},
        {OP_WD, 8'h81, 8'h00, 4'd7},
        {OP_RD, 8'h00, 8'h81, 4'd7},   // R7 low write
        {OP_WI, 8'hAA, 8'h00, 4'd2},   // R2 close
        {OP_RD, 8'h00, 8'hFF, 4'd2},
        {OP_RI, 8'h00, 8'hFF, 4'd2},
        {OP_WD, 8'h00, 8'h00, 4'd3},   // R3 closed data write
        {OP_WI, 8'h30, 8'h00, 4'd3},   // R3 closed index write
        {OP_WI, 8'h55, 8'h00, 4'd2},
        {OP_RI, 8'h00, 8'h66, 4'd3},   // R3 index kept
        {OP_RD, 8'h00, 8'h81, 4'd3},   // R3 data kept
        {OP_WI, 8'h07, 8'h00, 4'd8},
        {OP_WD, 8'h05, 8'h00, 4'd8},
        {OP_WI, 8'h66, 8'h00, 4'd8},
        {OP_RD, 8'h00, 8'h00, 4'd8},   // R8 other device reads 0
        {OP_WD, 8'h77, 8'h00, 4'd8},
        {OP_WI, 8'h07, 8'h00, 4'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cfg_port_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual valid/data %h, expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = w;
        bus_rd    = r;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        summary();
    end

    initial begin
        do_reset();
        // R1: no response pulse out of reset
        check("R1", {bus_rvalid, 8'h00}, {1'b0, 8'h00});

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [7:0] v, e;
            logic [3:0] rq;
            {op, v, e, rq} = VEC[i];
            case (op)
                OP_WI: access(IDX_A, 1'b1, 1'b0, v);
                OP_WD: access(DAT_A, 1'b1, 1'b0, v);
                OP_RI: begin
                    access(IDX_A, 1'b0, 1'b1, 8'h00);
                    check($sformatf("R%0d vec %0d", rq, i), {bus_rvalid, bus_rdata}, {1'b1, e});
                end
                default: begin
                    access(DAT_A, 1'b0, 1'b1, 8'h00);
                    check($sformatf("R%0d vec %0d", rq, i), {bus_rvalid, bus_rdata}, {1'b1, e});
                end
            endcase
        end

        // R8: reselect the controller device, stored bytes return
        access(DAT_A, 1'b1, 1'b0, 8'h0C);
        access(IDX_A, 1'b1, 1'b0, 8'h66);
        access(DAT_A, 1'b0, 1'b1, 8'h00);
        check("R8 base low after reselect", {bus_rvalid, bus_rdata}, {1'b1, 8'h81});

        // R11: pulse lasts one cycle
        @(negedge clk);
        check("R11 valid drops", {bus_rvalid, 8'h00}, {1'b0, 8'h00});

        // R10: foreign addresses touch nothing
        access(16'h004D, 1'b1, 1'b0, 8'hAA);
        access(16'h0050, 1'b1, 1'b0, 8'h00);
        access(16'h0050, 1'b0, 1'b1, 8'h00);
        check("R10 no pulse off-port", {bus_rvalid, 8'h00}, {1'b0, 8'h00});
        access(DAT_A, 1'b0, 1'b1, 8'h00);
        check("R10 state unchanged", {bus_rvalid, bus_rdata}, {1'b1, 8'h81});

        // R2: 0x55 while open becomes an index; R9 it is unimplemented
        access(IDX_A, 1'b1, 1'b0, 8'h55);
        access(IDX_A, 1'b0, 1'b1, 8'h00);
        check("R2 key as index", {bus_rvalid, bus_rdata}, {1'b1, 8'h55});
        access(DAT_A, 1'b0, 1'b1, 8'h00);
        check("R9 unimplemented", {bus_rvalid, bus_rdata}, {1'b1, 8'h00});

        // R1 / R7: reset mid-run restores closed state and defaults
        do_reset();
        access(DAT_A, 1'b0, 1'b1, 8'h00);
        check("R1 closed after reset", {bus_rvalid, bus_rdata}, {1'b1, 8'hFF});
        access(IDX_A, 1'b1, 1'b0, 8'h55);
        access(IDX_A, 1'b1, 1'b0, 8'h07);
        access(DAT_A, 1'b1, 1'b0, 8'h0C);
        access(IDX_A, 1'b1, 1'b0, 8'h66);
        access(DAT_A, 1'b0, 1'b1, 8'h00);
        check("R7 base low restored", {bus_rvalid, bus_rdata}, {1'b1, 8'h40});
        access(IDX_A, 1'b1, 1'b0, 8'h30);
        access(DAT_A, 1'b0, 1'b1, 8'h00);
        check("R6 flag restored", {bus_rvalid, bus_rdata}, {1'b1, 8'h01});

        summary();
    end

endmodule